// File: doc/BRIEF.md
# Three-Wire Tuning Word Receiver

This block takes a tuning word from a host over a three-wire serial bus: one data line, one bus clock and one enable. All three lines are asynchronous to the system clock. They pass through a synchroniser and edge detection, and are then handled entirely in the system clock domain.

While enable is high, each rising edge of the bus clock shifts one data bit into a shift register, most significant bit first. When enable goes low, the block splits the shifted word into a divisor field and four port bits, and loads them into holding registers. The holding registers drive the outputs directly. Between these loads, the outputs keep their values.

A mode-select pin chooses between two word formats:
- **Short format (mode pin high):** an 18-bit word. The divisor field has 14 bits, and the top divisor output bit is forced to zero.
- **Long format (mode pin low):** a 19-bit word. The divisor field has all 15 bits.

Top module: `tw_tune_rx`

## Requirements
- R1: Bits enter the shift register only while the synchronised enable is high. Bus clock edges seen while enable is low leave the shifted contents unchanged.
- R2: `port_o` and `divisor_o` change only as a result of a high-to-low transition of enable. At all other times they hold their previous values, including during a word transfer.
- R3: Data is sampled on the rising edge of the bus clock. The first bit sent is the most significant bit of the word.
- R4: With `mode_short_i` low, the word is 19 bits. Word bits 18, 17, 16 and 15 go to `port_o[3]`, `port_o[2]`, `port_o[1]` and `port_o[0]`. Word bits 14..0 go to `divisor_o[14:0]`.
- R5: With `mode_short_i` high, the word is 18 bits. Word bits 17..14 go to `port_o[3:0]` in the same order. Word bits 13..0 go to `divisor_o[13:0]`, and `divisor_o[14]` is 0.
- R6: If more bits arrive in one enable-high period than the word length, only the last 18 or 19 bits received are used.
- R7: Each of the four port bits follows its own word bit, independent of the other three.
- R8: The new values appear at the outputs after exactly the third rising edge of `clk` after the enable input falls. Each level of the bus clock must last at least four system clock cycles.
- R9: After reset, `port_o` is 0 and `divisor_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data_i | input | 1 | Serial data line |
| bus_clk_i | input | 1 | Serial bus clock |
| bus_en_i | input | 1 | Transfer enable; a falling edge loads the word |
| mode_short_i | input | 1 | Format select: 1 = 18-bit word, 0 = 19-bit word |
| port_o | output | 4 | Port bits; bit 3 is the first port field bit |
| divisor_o | output | 15 | Divisor value |

## Verification
The hardest situation to reach is proving that bus clock pulses are ignored while enable is low. A full-length word overwrites every bit of the shift register, which would hide any stray shifting. To expose it, the stimulus sends a burst of clock pulses with data held high while enable is low. It then sends a frame of only three bits, so the loaded word is mostly earlier shift contents that the stray pulses would have corrupted.

A cycle-exact reference model predicts the third-edge update after each enable fall. The bench compares the outputs with the model on every clock, which pins down both the latency and the hold behaviour.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic {
      WORD_LONG  = 1'b0,
      WORD_SHORT = 1'b1
   } word_fmt_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
   parameter int LEN = 19
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sclk_i,
   input  logic           sdat_i,
   input  logic           sen_i,
   output logic [LEN-1:0] word_o
);
   logic           sclk_prev;
   logic           sclk_rise;
   logic [LEN-1:0] word_q;

   assign sclk_rise = sclk_i & ~sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         word_q    <= '0;
      end else begin
         sclk_prev <= sclk_i;
         if (sclk_rise && sen_i)
            word_q <= {word_q[LEN-2:0], sdat_i};
      end
   end

   assign word_o = word_q;

   AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !sen_i |=> $stable(word_q)); // R1
endmodule

// File: rtl/tw_latch.sv
module tw_latch #(
   parameter int LONG_LEN  = 19,
   parameter int SHORT_LEN = 18,
   parameter int PORTS     = 4,
   localparam int DIV_W    = LONG_LEN - PORTS,
   localparam int SDIV_W   = SHORT_LEN - PORTS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sen_i,
   input  logic                mode_short_i,
   input  logic [LONG_LEN-1:0] word_i,
   output logic [PORTS-1:0]    port_o,
   output logic [DIV_W-1:0]    div_o
);
   import tw_pkg::*;

   logic             en_prev;
   logic             en_fall;
   logic [PORTS-1:0] long_port, short_port, next_port;
   logic [DIV_W-1:0] long_div, short_div, next_div;
   word_fmt_e        fmt;

   assign long_port  = word_i[LONG_LEN-1 -: PORTS];
   assign long_div   = word_i[DIV_W-1:0];
   assign short_port = word_i[SHORT_LEN-1 -: PORTS];

   if (DIV_W > SDIV_W) begin : g_pad
      assign short_div = {{(DIV_W-SDIV_W){1'b0}}, word_i[SDIV_W-1:0]};
   end else begin : g_nopad
      assign short_div = word_i[DIV_W-1:0];
   end

   assign fmt     = word_fmt_e'(mode_short_i);
   assign en_fall = en_prev & ~sen_i;

   always_comb begin
      if (fmt == WORD_SHORT) begin
         next_port = short_port;
         next_div  = short_div;
      end else begin
         next_port = long_port;
         next_div  = long_div;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev <= 1'b0;
         port_o  <= '0;
         div_o   <= '0;
      end else begin
         en_prev <= sen_i;
         if (en_fall) begin
            port_o <= next_port;
            div_o  <= next_div;
         end
      end
   end

   AST_HOLD_UNTIL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !en_fall |=> ($stable(port_o) && $stable(div_o))); // R2
   AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      en_fall |=> !en_fall); // R2
   AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en_fall && mode_short_i) |=> (div_o[DIV_W-1] == 1'b0)); // R5
   AST_LONG_PORT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_fall && !mode_short_i) |=> (port_o[PORTS-1] == $past(word_i[LONG_LEN-1]))); // R4
endmodule

// File: rtl/tw_tune_rx.sv
module tw_tune_rx #(
   parameter int SYNC_STAGES = 2,
   parameter int LONG_LEN    = 19,
   parameter int SHORT_LEN   = 18,
   parameter int PORT_BITS   = 4,
   localparam int DIV_W      = LONG_LEN - PORT_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_data_i,
   input  logic                 bus_clk_i,
   input  logic                 bus_en_i,
   input  logic                 mode_short_i,
   output logic [PORT_BITS-1:0] port_o,
   output logic [DIV_W-1:0]     divisor_o
);
   initial begin
      if (SYNC_STAGES < 2)
         $fatal(1, "tw_tune_rx: SYNC_STAGES must be at least 2");
      if (SHORT_LEN >= LONG_LEN)
         $fatal(1, "tw_tune_rx: SHORT_LEN must be below LONG_LEN");
      if (SHORT_LEN <= PORT_BITS)
         $fatal(1, "tw_tune_rx: SHORT_LEN must exceed PORT_BITS");
   end

   logic [3:0]          raw_in, synced;
   logic                s_dat, s_clk, s_en, s_mode;
   logic [LONG_LEN-1:0] word;

   assign raw_in = {mode_short_i, bus_en_i, bus_clk_i, bus_data_i};

   tw_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(synced)
   );

   assign {s_mode, s_en, s_clk, s_dat} = synced;

   tw_shift #(.LEN(LONG_LEN)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk_i(s_clk), .sdat_i(s_dat),
      .sen_i(s_en), .word_o(word)
   );

   tw_latch #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .PORTS(PORT_BITS)) u_latch (
      .clk(clk), .rst_n(rst_n), .sen_i(s_en), .mode_short_i(s_mode),
      .word_i(word), .port_o(port_o), .div_o(divisor_o)
   );
endmodule

// File: tb/tw_tune_rx_tb_top.sv
`timescale 1ns/1ps
module tw_tune_rx_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_data = 1'b0, bus_clk = 1'b0, bus_en = 1'b0, mode_short = 1'b0;
   logic [3:0]  port_o;
   logic [14:0] divisor_o;

   int checks = 0, failures = 0;
   bit mon_on = 1'b0, done = 1'b0;

   logic [18:0] sh = '0;      // reference shift contents
   logic [3:0]  exp_p = '0;
   logic [14:0] exp_d = '0;

   always #5 clk = ~clk;

   tw_tune_rx dut_i (
      .clk(clk), .rst_n(rst_n), .bus_data_i(bus_data), .bus_clk_i(bus_clk),
      .bus_en_i(bus_en), .mode_short_i(mode_short), .port_o(port_o), .divisor_o(divisor_o)
   );

   // Per-clock comparison against the reference model (R2, R8)
   always @(negedge clk) begin
      if (mon_on && !done) begin
         checks++;
         if (port_o !== exp_p || divisor_o !== exp_d) begin
            failures++;
            $display("FAIL R2/R8 cycle compare at %0t: actual port=%h div=%h expected port=%h div=%h",
                     $time, port_o, divisor_o, exp_p, exp_d);
         end
      end
   end

   task automatic chk(input string req);
      @(negedge clk);
      checks++;
      if (port_o !== exp_p || divisor_o !== exp_d) begin
         failures++;
         $display("FAIL %s: actual port=%h div=%h expected port=%h div=%h",
                  req, port_o, divisor_o, exp_p, exp_d);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic en_up(input bit short_m);
      mode_short = short_m;
      step(4);
      bus_en = 1'b1;
      step(4);
   endtask

   task automatic shift_bit(input bit b);
      bus_data = b;
      step(4);
      bus_clk = 1'b1;
      sh = {sh[17:0], b};
      step(4);
      bus_clk = 1'b0;
   endtask

   task automatic en_down();
      step(4);
      bus_en = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      if (mode_short) begin
         exp_p = sh[17:14];
         exp_d = {1'b0, sh[13:0]};
      end else begin
         exp_p = sh[18:15];
         exp_d = sh[14:0];
      end
      step(4);
   endtask

   task automatic send(input bit short_m, input int nbits, input logic [31:0] val);
      en_up(short_m);
      for (int i = nbits - 1; i >= 0; i--) shift_bit(val[i]);
      en_down();
   endtask

   task automatic stray_clock(input bit b);
      bus_data = b;
      step(4);
      bus_clk = 1'b1;
      step(4);
      bus_clk = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R8 watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      mon_on = 1'b1;
      chk("R9 reset state");

      // R3 R4: long format, MSB first
      send(1'b0, 19, {13'd0, 4'b1010, 15'h5A5A});
      chk("R4 long format fields");
      send(1'b0, 19, {13'd0, 4'b0011, 15'h7FFF});
      chk("R3 long format all-ones divisor");

      // R5: short format forces divisor MSB low after a long word set it
      send(1'b1, 18, {14'd0, 4'b0101, 14'h2B3C});
      chk("R5 short format fields");
      send(1'b1, 18, 32'h3FFFF);
      chk("R5 short format all ones");

      // R2: full word shifted but enable still high -> old outputs hold
      en_up(1'b0);
      for (int i = 18; i >= 0; i--) shift_bit(i[0]);
      step(6);
      chk("R2 hold while enable high");
      en_down();
      chk("R2 update on enable fall");

      // R6: 23 bits, only the last 19 count
      send(1'b0, 23, {9'd0, 4'b1001, 4'b0110, 15'h1234});
      chk("R6 excess bits");

      // R1: stray clocks with data high while enable low, then short frame
      send(1'b0, 19, 32'd0);
      chk("R1 clear word");
      for (int i = 0; i < 6; i++) stray_clock(1'b1);
      chk("R1 stray clocks no output change");
      send(1'b0, 3, 32'b101);
      chk("R1 stray clocks ignored");

      // R7: walking port bits
      for (int k = 0; k < 4; k++) begin
         send(1'b0, 19, {13'd0, 4'b0001 << k, 15'h0A0A});
         chk("R7 independent port bit");
      end
      send(1'b1, 18, {14'd0, 4'b1000, 14'h0001});
      chk("R7 short format single port");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule